// File: doc/BRIEF.md
# Latency-Insensitive Register Node

This block wraps a register, or a short chain of registers, as a dataflow node. It has one bounded input queue and one bounded output queue, and each queue uses a valid/ready handshake at the port. The node works in two alternating steps. In the first step it pushes the value of the last stage into the output queue. In the second step it pops one token from the input queue, loads that token into the first stage and moves every stage one place along. No output depends on the input token that arrives in the same round, and every output is paid back by exactly one input. Because of this the node can sit in a feedback loop, including one that sends its own output straight back to its input through single-entry queues, and it does not deadlock.

The chain depth, data width, queue depths and the per-stage initial values are all parameters. A chain depth of 1 gives a plain register and a depth of 2 gives a two-stage shift register. The asynchronous reset restores the initial values and empties both queues.

Top module: `li_reg_node`

## Requirements
- R1: While reset is asserted and directly after it is released, out_valid_o is 0 and in_ready_o is 1, because both queues are empty.
- R2: The output token sequence begins with the initial values, starting at the last stage (index DEPTH-1) and ending at stage 0. Stage i takes its initial value from bits [i*DATA_W +: DATA_W] of INIT_VALS. After these come the accepted input tokens, in the order they were accepted.
- R3: The node produces its first output with no input present. After each output it produces no further output until it has consumed one input token. With no input, exactly one token ever appears after reset.
- R4: While the output is blocked (out_ready_i held at 0), the node accepts exactly IN_Q_DEPTH + OUT_Q_DEPTH input tokens before in_ready_o stays low.
- R5: When out_data_o/out_valid_o feed in_data_i/in_valid_i and in_ready_o gates out_ready_i, tokens keep moving under any handshake gating. The sequence repeats the initial values cyclically, in last-stage-first order.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged on the next cycle.
- R7: A reset applied in mid-run discards all queued tokens. The output sequence then restarts from the initial values.
- R8: Under random valid and ready patterns on both ports, no token is lost, duplicated or reordered relative to R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input token valid |
| in_data_i | input | DATA_W | Input token data |
| in_ready_o | output | 1 | Input queue has space |
| out_valid_o | output | 1 | Output queue holds a token |
| out_data_o | output | DATA_W | Output token at queue head |
| out_ready_i | input | 1 | Consumer accepts the output token |

## Verification
The hardest situation to reach from the ports is a closed loop in which the node's only supply of input is its own earlier output, passing through single-entry queues. A design that waits for input before it emits stalls at once in this setup. The bench builds the loop by wiring the output handshake back to the input through a random gate, and it checks both the longest gap between tokens and the repeating value pattern. The blocked-output case is reached separately by holding ready low while input is offered, which shows how many tokens the node absorbs before it refuses more.

// File: rtl/li_reg_pkg.sv
package li_reg_pkg;
  typedef enum logic {
    ST_EMIT = 1'b0,
    ST_TAKE = 1'b1
  } node_st_e;
endpackage

// File: rtl/li_fifo.sv
module li_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o
);

  if (DEPTH == 1) begin : g_single
    logic         vld_q;
    logic [W-1:0] dat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        if (push_i) begin
          vld_q <= 1'b1;
          dat_q <= data_i;
        end else if (pop_i) begin
          vld_q <= 1'b0;
        end
      end
    end

    assign full_o  = vld_q;
    assign empty_o = !vld_q;
    assign data_o  = dat_q;
  end else begin : g_ring
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
      if (push_i) mem_q[wr_ptr_q] <= data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        cnt_q    <= '0;
      end else begin
        if (push_i) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        if (pop_i)  rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
        unique case ({push_i, pop_i})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign data_o  = mem_q[rd_ptr_q];
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  // R6
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i) |=> (!empty_o && $stable(data_o)));

endmodule

// File: rtl/li_reg_chain.sv
module li_reg_chain #(
  parameter int                     W         = 8,
  parameter int                     DEPTH     = 1,
  parameter logic [DEPTH*W-1:0]     INIT_VALS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);

  logic [DEPTH-1:0][W-1:0] stage_q;

  if (DEPTH == 1) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q <= INIT_VALS;
      else if (shift_i) stage_q <= data_i;
    end
  end else begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q <= INIT_VALS;
      else if (shift_i) stage_q <= {stage_q[DEPTH-2:0], data_i};
    end
  end

  assign data_o = stage_q[DEPTH-1];

  // R3
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(data_o));

endmodule

// File: rtl/li_node_ctrl.sv
module li_node_ctrl
  import li_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_space_i,
  input  logic in_avail_i,
  output logic emit_o,
  output logic take_o,
  output logic done_o
);

  node_st_e st_q;

  assign emit_o = (st_q == ST_EMIT) && out_space_i;
  assign take_o = (st_q == ST_TAKE) && in_avail_i;
  assign done_o = (st_q == ST_TAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= ST_EMIT;
    else if (emit_o) st_q <= ST_TAKE;
    else if (take_o) st_q <= ST_EMIT;
  end

  // outputs-minus-inputs balance, used only by the checks below
  logic [1:0] bal_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bal_q <= '0;
    else if (emit_o) bal_q <= bal_q + 1'b1;
    else if (take_o) bal_q <= bal_q - 1'b1;
  end

  // R3
  sc_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |-> (bal_q == 2'd0));

  // R3
  sc_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (bal_q == 2'd1));

  // R3
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(emit_o && take_o));

endmodule

// File: rtl/li_reg_node.sv
module li_reg_node #(
  parameter int                       DATA_W      = 8,
  parameter int                       DEPTH       = 2,
  parameter int                       IN_Q_DEPTH  = 1,
  parameter int                       OUT_Q_DEPTH = 1,
  parameter logic [DEPTH*DATA_W-1:0]  INIT_VALS   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);

  logic              in_full, in_empty, out_full, out_empty;
  logic              in_push, out_pop;
  logic              emit, take, done;
  logic [DATA_W-1:0] in_head, chain_out;

  assign in_push     = in_valid_i && !in_full;
  assign out_pop     = out_valid_o && out_ready_i;
  assign in_ready_o  = !in_full;
  assign out_valid_o = !out_empty;

  li_fifo #(.W(DATA_W), .DEPTH(IN_Q_DEPTH)) in_q_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_push),
    .data_i  (in_data_i),
    .full_o  (in_full),
    .pop_i   (take),
    .data_o  (in_head),
    .empty_o (in_empty)
  );

  li_node_ctrl ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .out_space_i (!out_full),
    .in_avail_i  (!in_empty),
    .emit_o      (emit),
    .take_o      (take),
    .done_o      (done)
  );

  li_reg_chain #(.W(DATA_W), .DEPTH(DEPTH), .INIT_VALS(INIT_VALS)) chain_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (take),
    .data_i  (in_head),
    .data_o  (chain_out)
  );

  li_fifo #(.W(DATA_W), .DEPTH(OUT_Q_DEPTH)) out_q_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (emit),
    .data_i  (chain_out),
    .full_o  (out_full),
    .pop_i   (out_pop),
    .data_o  (out_data_o),
    .empty_o (out_empty)
  );

  // R3: output step needs only space, never input
  ned_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done && !out_full) |=> out_valid_o);

  // R3: after emitting, no further output until an input is consumed
  wait_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && in_empty) |=> done);

  // R5: a waiting input always completes the round
  finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !in_empty) |=> !done);

endmodule

// File: tb/li_reg_node_tb_top.sv
module li_reg_node_tb_top;
  localparam int W  = 8;
  localparam int D  = 2;
  localparam int IQ = 1;
  localparam int OQ = 1;
  localparam logic [D*W-1:0] INIT = {8'hB2, 8'hA1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         loop_en = 1'b0, gate = 1'b0, drv_valid = 1'b0, drv_ready = 1'b0;
  logic [W-1:0] drv_data = '0;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [W-1:0] in_data, out_data;

  assign in_valid  = loop_en ? (out_valid && gate) : drv_valid;
  assign in_data   = loop_en ? out_data : drv_data;
  assign out_ready = loop_en ? (in_ready && gate) : drv_ready;

  li_reg_node #(.DATA_W(W), .DEPTH(D), .IN_Q_DEPTH(IQ), .OUT_Q_DEPTH(OQ),
                .INIT_VALS(INIT)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_data_o  (out_data),
    .out_ready_i (out_ready)
  );

  int errors = 0, checks = 0, cyc = 0;
  int got = 0, acc = 0, gap = 0, max_gap = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] next_data = 8'h10;
  logic [W-1:0] prev_data;
  bit prev_hold = 0;
  string tag = "R2";

  function automatic logic [W-1:0] init_of(input int stage);
    return INIT[stage*W +: W];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_reset;
    exp_q.delete();
    for (int i = D - 1; i >= 0; i--) exp_q.push_back(init_of(i));
    got = 0; acc = 0; gap = 0; max_gap = 0; prev_hold = 0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; loop_en = 1'b0; gate = 1'b0; drv_valid = 1'b0; drv_ready = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic observe;
    logic [W-1:0] e;
    if (prev_hold)
      chk(out_valid && out_data == prev_data, "R6", {out_valid, out_data}, {1'b1, prev_data});
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    if (out_valid && out_ready) begin
      got++;
      gap = 0;
      if (exp_q.size() == 0) begin
        chk(1'b0, tag, out_data, 0);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e, tag, out_data, e);
      end
      if (loop_en) exp_q.push_back(out_data);
    end else begin
      gap++;
      if (gap > max_gap) max_gap = gap;
    end
    if (!loop_en && in_valid && in_ready) begin
      exp_q.push_back(drv_data);
      acc++;
      next_data = next_data + 8'd1;
    end
  endtask

  // v: input valid (gate in loop mode), r: output ready
  task automatic tick(input bit v, input bit r);
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    drv_valid = v; drv_ready = r; gate = v; drv_data = next_data;
    #1;
    observe();
  endtask

  initial begin
    void'($urandom(32'd1234));

    // R1, R2, R3: first output needs no input, then one per input
    do_reset();
    tag = "R2";
    repeat (20) tick(1'b0, 1'b1);
    chk(got == 1, "R3 single output without input", got, 1);
    for (int i = 0; i < 20 && acc < 1; i++) tick(1'b1, 1'b1);
    repeat (20) tick(1'b0, 1'b1);
    chk(got == 2, "R3 one output per input", got, 2);
    for (int i = 0; i < 40 && acc < 5; i++) tick(1'b1, 1'b1);
    repeat (20) tick(1'b0, 1'b1);
    chk(got == acc + 1, "R2 directed stream count", got, acc + 1);

    // R4: blocked output absorbs a bounded number of inputs
    do_reset();
    repeat (30) tick(1'b1, 1'b0);
    chk(acc == IQ + OQ, "R4 accepted while blocked", acc, IQ + OQ);
    chk(!in_ready, "R4 input refused", in_ready, 0);
    repeat (40) tick(1'b0, 1'b1);
    chk(got == acc + 1, "R3 drain count", got, acc + 1);

    // R8: random handshakes in open mode
    tag = "R8";
    repeat (3000) tick(($urandom % 4) != 0, ($urandom % 3) != 0);

    // R7: reset in mid-run restarts from initial values
    repeat (7) tick(1'b1, 1'b0);
    tag = "R7";
    do_reset();
    repeat (400) tick(($urandom % 2) != 0, ($urandom % 2) != 0);
    chk(got >= D, "R7 restart produced output", got, D);

    // R5: self loop, full rate then random gating
    do_reset();
    loop_en = 1'b1;
    tag = "R5";
    repeat (200) tick(1'b1, 1'b0);
    chk(got >= 50, "R5 loop rate ungated", got, 50);
    chk(max_gap <= 10, "R5 gap ungated", max_gap, 10);
    got = 0; max_gap = 0; gap = 0;
    repeat (2000) tick(($urandom % 10) < 7, 1'b0);
    chk(got >= 100, "R5 loop progress gated", got, 100);
    chk(max_gap <= 60, "R5 gap gated", max_gap, 60);
    chk(exp_q.size() == D - 1 || exp_q.size() == D, "R5 loop token count",
        exp_q.size(), D);

    finish_run();
  end
endmodule